// File: doc/BRIEF.md
# Fractional PLL Coefficient Calculator

This block turns a requested VCO frequency into the programming words a fractional-N PLL needs. It takes a VCO frequency, a reference clock frequency, a VCO post-division ratio, a serial bit-clock rate and a spread-spectrum request. From these it derives the integer feedback divider, a 20-bit fractional divider, the lock-detector compare count, three loop-filter codes (charge pump, resistor, capacitor) and an integral loop gain. The multi-byte words come out already split into the narrow fields that configuration registers expect.

All quotients come from a single restoring shift-subtract divider that works on 64-bit unsigned values and produces one quotient bit per cycle. A controller steps through the quotients in a fixed order, so later steps can use earlier results. A one-cycle start launches the work and a one-cycle done reports completion. An inverse mode uses the same divider to recover the pixel rate from a lock-compare count. Choosing the post-divider and writing the registers are left to the surrounding logic.

Top module: `fpll_coef_calc`

## Requirements
- R1: The integer divider output `int_div` is floor(VCO / (4 x reference)), given as its low 16 bits.
- R2: The fraction is floor(VCO x 2^20 / (4 x reference)) minus `int_div` x 2^20, plus one when the remainder of that division is strictly greater than half the divisor (the divisor shifted right by one). Its bits [7:0], [15:8] and [19:16] appear on `frac_lo`, `frac_mid` and `frac_hi`.
- R3: The lock count is floor(1024 x floor(VCO / ratio) / (10 x reference)), plus one when the remainder is strictly greater than half the divisor, minus one. Its bits [7:0], [15:8] and [17:16] appear on `lock_lo`, `lock_mid` and `lock_hi`.
- R4: When the full fraction is nonzero or `ssc_req` is 1, `rc_code` is 0x16, `cc_code` is 0x28 and `cp_code` is floor(11000000 / floor(reference / 20)). Otherwise the three codes are 0x10, 0x01 and 0x23.
- R5: The gain base is floor(64 x reference / 19200000) when the mode of R4 is fractional, and floor(1022 x reference / 100) otherwise. The base is shifted left by 1 when the bit clock is at least 1500000000 and by 2 otherwise, then capped at 2046. Bits [7:0] of the result appear on `gain_lo` and bits [11:8] on `gain_hi`.
- R6: With `inv_mode` at 1 when start is taken, `pix_hz` becomes floor(floor((count + 1) x reference x 10 / 1024) / 10), where count is `cmp_cnt_in`.
- R7: `start` is taken only while `busy` is 0. `busy` rises on the following cycle. `done` is high for exactly one cycle, with `busy` low. Done appears 66 cycles per quotient after the start edge: 462 cycles in forward mode (7 quotients) and 132 in inverse mode (2 quotients).
- R8: A `start` pulse while `busy` is 1 is ignored. The results still match the inputs presented at the accepted start, and the latency is unchanged.
- R9: Every output holds its value from `done` until the next accepted start.
- R10: During and directly after reset, `busy` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch a computation (taken while idle) |
| inv_mode | input | 1 | 1 selects pixel-rate recovery |
| vco_hz | input | 64 | VCO frequency in Hz |
| ref_hz | input | 32 | Reference frequency in Hz |
| post_ratio | input | 8 | VCO post-division ratio |
| bit_hz | input | 64 | Serial bit-clock rate in Hz |
| ssc_req | input | 1 | Spread-spectrum request |
| cmp_cnt_in | input | 18 | Lock-compare count for inverse mode |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle completion pulse |
| int_div | output | 16 | Integer feedback divider |
| frac_lo | output | 8 | Fraction bits [7:0] |
| frac_mid | output | 8 | Fraction bits [15:8] |
| frac_hi | output | 4 | Fraction bits [19:16] |
| lock_lo | output | 8 | Lock count bits [7:0] |
| lock_mid | output | 8 | Lock count bits [15:8] |
| lock_hi | output | 2 | Lock count bits [17:16] |
| cp_code | output | 8 | Charge-pump code |
| rc_code | output | 8 | Resistor code |
| cc_code | output | 8 | Capacitor code |
| gain_lo | output | 8 | Loop gain bits [7:0] |
| gain_hi | output | 4 | Loop gain bits [11:8] |
| pix_hz | output | 64 | Recovered pixel rate in Hz |

## Verification
The assertions assume that `start` comes as a clean pulse and that the numeric inputs give nonzero divisors: a reference of at least 20 Hz and a nonzero ratio. They also assume that no intermediate product overflows 64 bits. The stimulus keeps the reference between 9.6 MHz and 38.4 MHz, the VCO between 8 GHz and 12 GHz, and the ratio between 2 and 35. Under these limits the lock count fits in 18 bits and the charge-pump code fits in 8 bits. Bit-clock values sit on both sides of the 1.5 GHz band edge and exactly on it. A second start is injected mid-run with different inputs, to show that it is ignored.

// File: rtl/fpll_coef_calc.sv
module fpll_coef_calc #(
  parameter int          FRAC_BITS = 20,
  parameter int          LOCK_LOG2 = 10,
  parameter logic [63:0] NOM_REF   = 64'd19200000,
  parameter logic [63:0] BAND_EDGE = 64'd1500000000,
  parameter logic [63:0] CP_NUM    = 64'd11000000,
  parameter logic [63:0] GAIN_CAP  = 64'd2046
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        inv_mode,
  input  logic [63:0] vco_hz,
  input  logic [31:0] ref_hz,
  input  logic [7:0]  post_ratio,
  input  logic [63:0] bit_hz,
  input  logic        ssc_req,
  input  logic [17:0] cmp_cnt_in,
  output logic        busy,
  output logic        done,
  output logic [15:0] int_div,
  output logic [7:0]  frac_lo,
  output logic [7:0]  frac_mid,
  output logic [3:0]  frac_hi,
  output logic [7:0]  lock_lo,
  output logic [7:0]  lock_mid,
  output logic [1:0]  lock_hi,
  output logic [7:0]  cp_code,
  output logic [7:0]  rc_code,
  output logic [7:0]  cc_code,
  output logic [7:0]  gain_lo,
  output logic [3:0]  gain_hi,
  output logic [63:0] pix_hz
);
  localparam int          W        = 64;
  localparam logic [3:0]  LAST_FWD = 4'd6;
  localparam logic [3:0]  FIRST_INV = 4'd7;
  localparam logic [3:0]  LAST_INV = 4'd8;
  localparam logic [63:0] K10      = 64'd10;
  localparam logic [63:0] K20      = 64'd20;
  localparam logic [63:0] K64      = 64'd64;
  localparam logic [63:0] K100     = 64'd100;
  localparam logic [63:0] K1022    = 64'd1022;
  localparam logic [63:0] LOCK_DEN = 64'd1 << LOCK_LOG2;

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_DIV, S_SAVE} st_t;
  st_t st;
  logic [3:0]  step;
  logic [5:0]  icnt;
  logic [63:0] vco_r, ref_r, bit_r, rat_r, cnt_r;
  logic        ssc_r;
  logic [63:0] q_dec, q_frac, q_fd, q_lock, q_r20, q_cp, q_gain, q_inv, q_pix;
  logic        rnd_frac, rnd_lock;
  logic [63:0] rem, quo, den_r, num_m, den_m;

  logic [64:0] shifted, diff;
  logic        ge;
  assign shifted = {rem, quo[W-1]};
  assign ge      = shifted >= {1'b0, den_r};
  assign diff    = shifted - {1'b0, den_r};

  logic [63:0] frac_full, lock_full, gain_sh, gain_sat;
  logic        frac_on;
  assign frac_full = q_frac - (q_dec << FRAC_BITS) + {63'd0, rnd_frac};
  assign frac_on   = (frac_full != 64'd0) || ssc_r;
  assign lock_full = q_lock + {63'd0, rnd_lock} - 64'd1;
  assign gain_sh   = (bit_r >= BAND_EDGE) ? (q_gain << 1) : (q_gain << 2);
  assign gain_sat  = (gain_sh > GAIN_CAP) ? GAIN_CAP : gain_sh;

  always_comb begin
    num_m = 64'd0;
    den_m = 64'd1;
    case (step)
      4'd0: begin num_m = vco_r;               den_m = ref_r << 2; end
      4'd1: begin num_m = vco_r << FRAC_BITS;  den_m = ref_r << 2; end
      4'd2: begin num_m = vco_r;               den_m = rat_r; end
      4'd3: begin num_m = q_fd << LOCK_LOG2;   den_m = ref_r * K10; end
      4'd4: begin num_m = ref_r;               den_m = K20; end
      4'd5: begin num_m = CP_NUM;              den_m = q_r20; end
      4'd6: begin
        num_m = frac_on ? ref_r * K64 : ref_r * K1022;
        den_m = frac_on ? NOM_REF : K100;
      end
      4'd7: begin num_m = (cnt_r + 64'd1) * ref_r * K10; den_m = LOCK_DEN; end
      4'd8: begin num_m = q_inv;               den_m = K10; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; step <= 4'd0; icnt <= 6'd0; done <= 1'b0;
      vco_r <= '0; ref_r <= '0; bit_r <= '0; rat_r <= '0; cnt_r <= '0; ssc_r <= 1'b0;
      q_dec <= '0; q_frac <= '0; q_fd <= '0; q_lock <= '0; q_r20 <= '0;
      q_cp <= '0; q_gain <= '0; q_inv <= '0; q_pix <= '0;
      rnd_frac <= 1'b0; rnd_lock <= 1'b0;
      rem <= '0; quo <= '0; den_r <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          vco_r <= vco_hz; ref_r <= {32'd0, ref_hz}; bit_r <= bit_hz;
          rat_r <= {56'd0, post_ratio}; cnt_r <= {46'd0, cmp_cnt_in}; ssc_r <= ssc_req;
          step  <= inv_mode ? FIRST_INV : 4'd0;
          st    <= S_LOAD;
        end
        S_LOAD: begin
          rem <= '0; quo <= num_m; den_r <= den_m; icnt <= 6'd0; st <= S_DIV;
        end
        S_DIV: begin
          rem  <= ge ? diff[W-1:0] : shifted[W-1:0];
          quo  <= {quo[W-2:0], ge};
          icnt <= icnt + 6'd1;
          if (icnt == 6'd63) st <= S_SAVE;
        end
        S_SAVE: begin
          case (step)
            4'd0: q_dec  <= quo;
            4'd1: begin q_frac <= quo; rnd_frac <= rem > (den_r >> 1); end
            4'd2: q_fd   <= quo;
            4'd3: begin q_lock <= quo; rnd_lock <= rem > (den_r >> 1); end
            4'd4: q_r20  <= quo;
            4'd5: q_cp   <= quo;
            4'd6: q_gain <= quo;
            4'd7: q_inv  <= quo;
            default: q_pix <= quo;
          endcase
          if (step == LAST_FWD || step == LAST_INV) begin
            done <= 1'b1;
            st   <= S_IDLE;
          end else begin
            step <= step + 4'd1;
            st   <= S_LOAD;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy     = st != S_IDLE;
  assign int_div  = q_dec[15:0];
  assign frac_lo  = frac_full[7:0];
  assign frac_mid = frac_full[15:8];
  assign frac_hi  = frac_full[19:16];
  assign lock_lo  = lock_full[7:0];
  assign lock_mid = lock_full[15:8];
  assign lock_hi  = lock_full[17:16];
  assign cp_code  = frac_on ? q_cp[7:0] : 8'h23;
  assign rc_code  = frac_on ? 8'h16 : 8'h10;
  assign cc_code  = frac_on ? 8'h28 : 8'h01;
  assign gain_lo  = gain_sat[7:0];
  assign gain_hi  = gain_sat[11:8];
  assign pix_hz   = q_pix;
endmodule

module fpll_coef_calc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic [7:0]  frac_lo,
  input logic [7:0]  lock_lo,
  input logic [7:0]  gain_lo,
  input logic [3:0]  gain_hi,
  input logic [63:0] pix_hz
);
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  // R7
  start_take_chk: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy);
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> ($stable(frac_lo) && $stable(lock_lo) && $stable(gain_lo) && $stable(pix_hz)));
  // R5
  gain_cap_chk: assert property (@(posedge clk) disable iff (!rst_n) {gain_hi, gain_lo} <= 12'd2046);
endmodule

bind fpll_coef_calc fpll_coef_calc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .frac_lo(frac_lo), .lock_lo(lock_lo), .gain_lo(gain_lo), .gain_hi(gain_hi), .pix_hz(pix_hz)
);

// File: tb/sim_fpll_coef_calc.sv
`timescale 1ns/1ps
module sim_fpll_coef_calc;
  localparam int QUO_CYC = 66;

  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0, inv_mode = 1'b0, ssc_req = 1'b0;
  logic [63:0] vco_hz = '0, bit_hz = '0;
  logic [31:0] ref_hz = '0;
  logic [7:0]  post_ratio = '0;
  logic [17:0] cmp_cnt_in = '0;
  logic        busy, done;
  logic [15:0] int_div;
  logic [7:0]  frac_lo, frac_mid, lock_lo, lock_mid, cp_code, rc_code, cc_code, gain_lo;
  logic [3:0]  frac_hi, gain_hi;
  logic [1:0]  lock_hi;
  logic [63:0] pix_hz;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  fpll_coef_calc u0 (.*);

  task automatic chk(input bit ok, input string req, input longint unsigned act, input longint unsigned exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_done(input int steps, input bit poke);
    int n = 0;
    bit busy_ok = 1;
    @(negedge clk);
    start = 1'b0;
    forever begin
      if (done) break;
      if (busy !== 1'b1) busy_ok = 0;
      if (poke && n == 100) begin
        start = 1'b1; inv_mode = ~inv_mode; vco_hz = 64'd11999999999; ref_hz = 32'd27000000;
        post_ratio = 8'd3; ssc_req = ~ssc_req; cmp_cnt_in = 18'd77;
      end
      if (poke && n == 101) start = 1'b0;
      n++;
      if (n > 5000) break;
      @(negedge clk);
    end
    chk(busy_ok, "R7 busy during run", 64'(busy_ok), 1);
    chk(n == steps * QUO_CYC, poke ? "R8 latency with ignored start" : "R7 latency",
        longint'(n), longint'(steps * QUO_CYC));
    chk(done === 1'b1 && busy === 1'b0, "R7 done with busy low", {62'd0, done, busy}, 2);
  endtask

  task automatic launch;
    @(negedge clk);
    start = 1'b1;
  endtask

  task automatic hold_check;
    logic [127:0] snap;
    bit ok = 1;
    snap = {int_div, frac_lo, frac_mid, frac_hi, lock_lo, lock_mid, lock_hi, cp_code, rc_code,
            cc_code, gain_lo, gain_hi, 2'b00};
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (done !== 1'b0) ok = 0;
      if ({int_div, frac_lo, frac_mid, frac_hi, lock_lo, lock_mid, lock_hi, cp_code, rc_code,
           cc_code, gain_lo, gain_hi, 2'b00} !== snap) ok = 0;
    end
    chk(ok, "R9/R7 hold after done", 64'(ok), 1);
  endtask

  task automatic run_fwd(input longint unsigned v, input longint unsigned r, input int unsigned rt,
                         input longint unsigned b, input bit s, input bit poke);
    longint unsigned dec, d4, q2, r2, frac, fd, ln, ld, lock, cp, base, sh, gain;
    bit fm;
    d4   = 4 * r;
    dec  = v / d4;
    q2   = (v << 20) / d4;
    r2   = (v << 20) % d4;
    frac = q2 - (dec << 20) + ((r2 > (d4 >> 1)) ? 1 : 0);
    fm   = (frac != 0) || s;
    fd   = v / rt;
    ln   = 1024 * fd;
    ld   = 10 * r;
    lock = ln / ld + (((ln % ld) > (ld >> 1)) ? 1 : 0) - 1;
    cp   = fm ? 11000000 / (r / 20) : 'h23;
    base = fm ? (64 * r) / 19200000 : (1022 * r) / 100;
    sh   = (b >= 64'd1500000000) ? base << 1 : base << 2;
    gain = (sh > 2046) ? 2046 : sh;
    vco_hz = v; ref_hz = 32'(r); post_ratio = 8'(rt); bit_hz = b; ssc_req = s; inv_mode = 1'b0;
    launch();
    wait_done(7, poke);
    chk(int_div == 16'(dec), "R1 integer divider", int_div, dec);
    chk({frac_hi, frac_mid, frac_lo} == 20'(frac), "R2 fraction fields", {frac_hi, frac_mid, frac_lo}, frac[19:0]);
    chk({lock_hi, lock_mid, lock_lo} == 18'(lock), "R3 lock count fields", {lock_hi, lock_mid, lock_lo}, lock[17:0]);
    chk(rc_code == (fm ? 8'h16 : 8'h10) && cc_code == (fm ? 8'h28 : 8'h01), "R4 rc/cc codes",
        {rc_code, cc_code}, fm ? 64'h1628 : 64'h1001);
    chk(cp_code == 8'(cp), "R4 charge-pump code", cp_code, cp);
    chk({gain_hi, gain_lo} == 12'(gain), "R5 loop gain", {gain_hi, gain_lo}, gain);
    hold_check();
  endtask

  task automatic run_inv(input int unsigned c, input longint unsigned r);
    longint unsigned e;
    e = ((longint'(c) + 1) * r * 10 / 1024) / 10;
    cmp_cnt_in = 18'(c); ref_hz = 32'(r); inv_mode = 1'b1;
    launch();
    wait_done(2, 1'b0);
    chk(pix_hz == e, "R6 inverse pixel rate", pix_hz, e);
    hold_check();
  endtask

  initial begin
    #1000000;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R10 reset state", {busy, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R10 after reset", {busy, done}, 0);
    run_fwd(64'd8064000000, 64'd19200000, 5, 64'd1000000000, 1'b0, 1'b0);
    run_fwd(64'd8064000000, 64'd19200000, 5, 64'd1000000000, 1'b1, 1'b0);
    run_fwd(64'd8100000000, 64'd19200000, 3, 64'd2700000000, 1'b0, 1'b0);
    run_fwd(64'd9000000000, 64'd19200000, 6, 64'd1500000000, 1'b0, 1'b0);
    run_fwd(64'd9000000000, 64'd19200000, 6, 64'd1499999999, 1'b0, 1'b0);
    run_fwd(64'd11880000000, 64'd38400000, 35, 64'd5940000000, 1'b0, 1'b0);
    run_fwd(64'd8910000000, 64'd9600000, 2, 64'd742500000, 1'b1, 1'b1);
    for (int i = 0; i < 12; i++) begin
      longint unsigned v, r;
      int unsigned rt;
      v  = 64'd8000000000 + longint'($urandom % 32'd4000000000);
      case ($urandom % 4) 0: r = 9600000; 1: r = 19200000; 2: r = 27000000; default: r = 38400000; endcase
      rt = 2 + ($urandom % 34);
      run_fwd(v, r, rt, 64'd1000000000 + longint'($urandom % 32'd1000000000), 1'($urandom), 1'b0);
    end
    run_inv(0, 19200000);
    run_inv(32767, 19200000);
    run_inv(262143, 38400000);
    run_inv(5000, 27000000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule